// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the status word that a non-volatile memory puts on its data bus while an internal program or erase is running, and it drives the ready/busy line. A command decoder tells it when an operation has been accepted, what kind it is, and which value bit 7 of the programmed word should take. The internal algorithm reports completion, a time-limit fault and the closing of the erase collection window. The host side supplies the read strobe and a flag that is high when the current read address falls in a sector selected for erase.

A six-state sequencer tracks the operation. `ST_IDLE` is the resting state. `ST_PGM` runs a program. `ST_ERWIN` is the erase collection window before the erase proper starts. `ST_ERRUN` runs the erase. `ST_ERSUSP` holds a suspended erase. `ST_LIMIT` holds an operation that ran past its time limit. The transitions are: start-program (IDLE to PGM), start-erase (IDLE to ERWIN), window-close (ERWIN to ERRUN), window-suspend (ERWIN to ERSUSP), suspend (ERRUN to ERSUSP), resume (ERSUSP to ERRUN), finish (PGM or ERRUN to IDLE), overrun (PGM or ERRUN to LIMIT) and abort (LIMIT to IDLE). On an overrun the time limit wins over completion, and completion wins over suspend. Two toggle cells advance on falling edges of the read strobe. An encoder then builds the status word from the state, the latched program bit and the toggle cells.

Top module: `opstat_gen`

## Requirements
- R1: After reset, and whenever reset is applied, the state is idle, `status` reads 0x80 and `ready` is 1.
- R2: While a program runs, or after it overruns, status bit 7 is the inverse of the latched `cmd_data_b7`. Once the program finishes or is aborted, bit 7 shows the latched value itself.
- R3: During an erase (window, running, suspended or overrun) status bit 7 is 0. After an erase finishes it is 1. `cmd_data_b7` has no effect on an erase.
- R4: Status bit 6 inverts once for each falling edge of `rd_strobe` seen while in PGM, ERWIN, ERRUN or LIMIT. It is cleared when a command starts. In idle, bits 6 to 0 read 0, and read edges change nothing.
- R5: An overrun sets status bit 5 and keeps `ready` at 0. Bit 6 goes on toggling and `op_done` is ignored. Only `abort_req` returns the block to idle.
- R6: Status bit 3 is 0 in the erase window. It is 1 while an erase runs or is suspended, including a suspend taken during the window, and in an erase overrun.
- R7: Status bit 2 inverts on a falling edge of `rd_strobe` only if `rd_in_sector` is 1 at that edge and the state is ERWIN, ERRUN or ERSUSP.
- R8: In ERSUSP, bit 6 holds its value and `ready` is 1. `res_req` returns the block to ERRUN with `ready` at 0. `sus_req` has no effect during a program.
- R9: `ready` is 0 from the clock edge that accepts `cmd_go` until the operation finishes, and `cmd_go` is only accepted in idle.
- R10: When `over_limit` and `op_done` are both high in PGM or ERRUN, the block enters LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_go | input | 1 | Command accepted (last write edge of the sequence) |
| cmd_is_erase | input | 1 | 1 = erase, 0 = program |
| cmd_data_b7 | input | 1 | Bit 7 of the word being programmed |
| op_done | input | 1 | Internal algorithm finished |
| over_limit | input | 1 | Internal time limit exceeded |
| sus_req | input | 1 | Erase suspend command |
| res_req | input | 1 | Erase resume command |
| abort_req | input | 1 | Reset command that clears an overrun |
| win_closed | input | 1 | Erase collection window has closed |
| rd_strobe | input | 1 | Read strobe level; falling edge marks a read |
| rd_in_sector | input | 1 | Read address lies in a sector chosen for erase |
| status | output | STATUS_W | Status word (bits 7, 6, 5, 3, 2 used) |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench goes after toggle behaviour across read-strobe edges. A design that toggled on every clock, or on rising edges, would show bit 6 changing with no read in between, or one cycle off. It checks the suspended erase, where a design that kept bit 6 running or left `ready` low would mislead a polling host. It checks the bit-2 sector flag being sampled at the falling edge itself, so a design that latched it late would toggle on the wrong read. It also drives completion and time-limit together, and sends a completion during an overrun: a wrong priority would return the block to idle and hide the fault.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PGM    = 3'd1,
        ST_ERWIN  = 3'd2,
        ST_ERRUN  = 3'd3,
        ST_ERSUSP = 3'd4,
        ST_LIMIT  = 3'd5
    } seq_state_t;

    typedef enum logic {
        OP_PGM = 1'b0,
        OP_ERS = 1'b1
    } op_kind_t;

    // status bit positions (decoded by host polling software)
    localparam int POLL_B  = 7;
    localparam int TOGA_B  = 6;
    localparam int LIMIT_B = 5;
    localparam int WIN_B   = 3;
    localparam int TOGS_B  = 2;

    // toggle cells: index 0 = whole-operation toggle, index 1 = sector toggle
    localparam int NUM_TOG  = 2;
    localparam int TOG_ALL  = 0;
    localparam int TOG_SECT = 1;

endpackage

// File: rtl/opstat_seq.sv
module opstat_seq
    import opstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  op_kind_t   cmd_kind,
    input  logic       cmd_data_b7,
    input  logic       op_done,
    input  logic       over_limit,
    input  logic       sus_req,
    input  logic       res_req,
    input  logic       abort_req,
    input  logic       win_closed,
    output seq_state_t state,
    output op_kind_t   cur_kind,
    output logic       held_b7
);

    seq_state_t nxt;
    logic       accept;

    assign accept = (state == ST_IDLE) && cmd_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_kind <= OP_ERS;
            held_b7  <= 1'b0;
        end else if (accept) begin
            cur_kind <= cmd_kind;
            held_b7  <= cmd_data_b7;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_go) begin
                    nxt = (cmd_kind == OP_PGM) ? ST_PGM : ST_ERWIN;
                end
            end
            ST_PGM: begin
                if (over_limit) begin
                    nxt = ST_LIMIT;
                end else if (op_done) begin
                    nxt = ST_IDLE;
                end
            end
            ST_ERWIN: begin
                if (sus_req) begin
                    nxt = ST_ERSUSP;
                end else if (win_closed) begin
                    nxt = ST_ERRUN;
                end
            end
            ST_ERRUN: begin
                if (over_limit) begin
                    nxt = ST_LIMIT;
                end else if (op_done) begin
                    nxt = ST_IDLE;
                end else if (sus_req) begin
                    nxt = ST_ERSUSP;
                end
            end
            ST_ERSUSP: begin
                if (res_req) begin
                    nxt = ST_ERRUN;
                end
            end
            ST_LIMIT: begin
                if (abort_req) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LIMIT && !abort_req) |=> (state == ST_LIMIT));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_go) |=> (state != ST_IDLE));

    // R10
    limit_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PGM || state == ST_ERRUN) && over_limit) |=> (state == ST_LIMIT));

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic rd_fall,
    output logic tog
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (clr) begin
            tog <= 1'b0;
        end else if (en && rd_fall) begin
            tog <= ~tog;
        end
    end

    // R4
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_fall && !clr) |=> (tog != $past(tog)));

endmodule

// File: rtl/opstat_encode.sv
module opstat_encode
    import opstat_pkg::*;
#(
    parameter int STATUS_W = 8
) (
    input  seq_state_t          state,
    input  op_kind_t            cur_kind,
    input  logic                held_b7,
    input  logic [NUM_TOG-1:0]  tog_v,
    output logic [STATUS_W-1:0] status,
    output logic                ready
);

    logic ers;

    assign ers = (cur_kind == OP_ERS);

    always_comb begin
        status = '0;
        ready  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                status[POLL_B] = ers ? 1'b1 : held_b7;
            end
            ST_PGM: begin
                status[POLL_B] = ~held_b7;
                status[TOGA_B] = tog_v[TOG_ALL];
                ready          = 1'b0;
            end
            ST_ERWIN: begin
                status[TOGA_B] = tog_v[TOG_ALL];
                status[TOGS_B] = tog_v[TOG_SECT];
                ready          = 1'b0;
            end
            ST_ERRUN: begin
                status[TOGA_B] = tog_v[TOG_ALL];
                status[TOGS_B] = tog_v[TOG_SECT];
                status[WIN_B]  = 1'b1;
                ready          = 1'b0;
            end
            ST_ERSUSP: begin
                status[TOGA_B] = tog_v[TOG_ALL];
                status[TOGS_B] = tog_v[TOG_SECT];
                status[WIN_B]  = 1'b1;
            end
            ST_LIMIT: begin
                status[POLL_B]  = ers ? 1'b0 : ~held_b7;
                status[TOGA_B]  = tog_v[TOG_ALL];
                status[LIMIT_B] = 1'b1;
                status[WIN_B]   = ers;
                ready           = 1'b0;
            end
            default: begin
                status = '0;
                ready  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
    import opstat_pkg::*;
#(
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_go,
    input  logic                cmd_is_erase,
    input  logic                cmd_data_b7,
    input  logic                op_done,
    input  logic                over_limit,
    input  logic                sus_req,
    input  logic                res_req,
    input  logic                abort_req,
    input  logic                win_closed,
    input  logic                rd_strobe,
    input  logic                rd_in_sector,
    output logic [STATUS_W-1:0] status,
    output logic                ready
);

    seq_state_t         state;
    op_kind_t           cur_kind;
    logic               held_b7;
    logic               rd_q;
    logic               rd_fall;
    logic               tog_clr;
    logic [NUM_TOG-1:0] tog_en;
    logic [NUM_TOG-1:0] tog_v;

    opstat_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd_kind   (cmd_is_erase ? OP_ERS : OP_PGM),
        .cmd_data_b7(cmd_data_b7),
        .op_done    (op_done),
        .over_limit (over_limit),
        .sus_req    (sus_req),
        .res_req    (res_req),
        .abort_req  (abort_req),
        .win_closed (win_closed),
        .state      (state),
        .cur_kind   (cur_kind),
        .held_b7    (held_b7)
    );

    // read strobe falling-edge detection in the core clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_strobe;
        end
    end

    assign rd_fall = rd_q && !rd_strobe;
    assign tog_clr = (state == ST_IDLE) && cmd_go;

    always_comb begin
        tog_en           = '0;
        tog_en[TOG_ALL]  = (state == ST_PGM) || (state == ST_ERWIN) ||
                           (state == ST_ERRUN) || (state == ST_LIMIT);
        tog_en[TOG_SECT] = rd_in_sector &&
                           ((state == ST_ERWIN) || (state == ST_ERRUN) ||
                            (state == ST_ERSUSP));
    end

    generate
        for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
            opstat_toggle u_tog (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (tog_clr),
                .en     (tog_en[g]),
                .rd_fall(rd_fall),
                .tog    (tog_v[g])
            );
        end
    endgenerate

    opstat_encode #(.STATUS_W(STATUS_W)) u_enc (
        .state   (state),
        .cur_kind(cur_kind),
        .held_b7 (held_b7),
        .tog_v   (tog_v),
        .status  (status),
        .ready   (ready)
    );

    // R5
    limit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[LIMIT_B] |-> !ready);

    // R8
    sus_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERSUSP) |=> ((state != ST_ERSUSP) || $stable(status[TOGA_B])));

    // R7
    sect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_in_sector && !tog_clr) |=> $stable(tog_v[TOG_SECT]));

endmodule

// File: tb/opstat_gen_tb.sv
module opstat_gen_tb;

    localparam int CLK_PER = 10;
    localparam int NROWS   = 39;

    // row: {go,kind,b7,done,lim,sus,res,abt,win,rd,sec, exp_status[7:0], exp_ready}
    localparam logic [19:0] ROWS [0:NROWS-1] = '{
        {11'b10100000000, 8'h00, 1'b0}, // 0  R2 start program, bit=1
        {11'b00000000010, 8'h00, 1'b0}, // 1
        {11'b00000000000, 8'h40, 1'b0}, // 2  R4 read fall
        {11'b00000000010, 8'h40, 1'b0}, // 3
        {11'b00000000000, 8'h00, 1'b0}, // 4  R4 second fall
        {11'b00010000000, 8'h80, 1'b1}, // 5  R2 finish -> true data
        {11'b00000000010, 8'h80, 1'b1}, // 6
        {11'b00000000000, 8'h80, 1'b1}, // 7  R4 idle read ignored
        {11'b10000000000, 8'h80, 1'b0}, // 8  R2 program bit=0
        {11'b00000000010, 8'h80, 1'b0}, // 9
        {11'b00000000000, 8'hC0, 1'b0}, // 10 R4
        {11'b00001000000, 8'hE0, 1'b0}, // 11 R5 overrun
        {11'b00000000010, 8'hE0, 1'b0}, // 12
        {11'b00000000000, 8'hA0, 1'b0}, // 13 R5 toggle continues
        {11'b00010000000, 8'hA0, 1'b0}, // 14 R5 done ignored
        {11'b00000001000, 8'h00, 1'b1}, // 15 R5 abort
        {11'b11100000000, 8'h00, 1'b0}, // 16 R3 start erase, b7 ignored
        {11'b00000000011, 8'h00, 1'b0}, // 17
        {11'b00000000001, 8'h44, 1'b0}, // 18 R7 in-sector fall
        {11'b00000000011, 8'h44, 1'b0}, // 19
        {11'b00000000000, 8'h04, 1'b0}, // 20 R7 out-of-sector fall
        {11'b00000000100, 8'h0C, 1'b0}, // 21 R6 window closes
        {11'b00000000011, 8'h0C, 1'b0}, // 22
        {11'b00000000001, 8'h48, 1'b0}, // 23 R7
        {11'b00000100000, 8'h48, 1'b1}, // 24 R8 suspend
        {11'b00000000011, 8'h48, 1'b1}, // 25
        {11'b00000000001, 8'h4C, 1'b1}, // 26 R7 sector toggles in suspend, R8 bit6 held
        {11'b00000000010, 8'h4C, 1'b1}, // 27
        {11'b00000000000, 8'h4C, 1'b1}, // 28 R8
        {11'b00000010000, 8'h4C, 1'b0}, // 29 R8 resume
        {11'b00010000000, 8'h80, 1'b1}, // 30 R3 erase done
        {11'b11000000000, 8'h00, 1'b0}, // 31 R9 start erase
        {11'b00000100000, 8'h08, 1'b1}, // 32 R6 suspend in window
        {11'b00000010000, 8'h08, 1'b0}, // 33 R8 resume
        {11'b00011000000, 8'h28, 1'b0}, // 34 R10 limit+done
        {11'b00000001000, 8'h80, 1'b1}, // 35 R5 abort erase overrun
        {11'b10100000000, 8'h00, 1'b0}, // 36 R9 start program
        {11'b00000100000, 8'h00, 1'b0}, // 37 R8 suspend ignored in program
        {11'b00010000000, 8'h80, 1'b1}  // 38 R2
    };

    localparam logic [23:0] TAGS [0:NROWS-1] = '{
        "R2", "R2", "R4", "R4", "R4", "R2", "R4", "R4", "R2", "R2",
        "R4", "R5", "R5", "R5", "R5", "R5", "R3", "R7", "R7", "R7",
        "R7", "R6", "R6", "R7", "R8", "R8", "R7", "R8", "R8", "R8",
        "R3", "R9", "R6", "R8", "R10", "R5", "R9", "R8", "R2"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0, cmd_is_erase = 1'b0, cmd_data_b7 = 1'b0;
    logic       op_done = 1'b0, over_limit = 1'b0, sus_req = 1'b0;
    logic       res_req = 1'b0, abort_req = 1'b0, win_closed = 1'b0;
    logic       rd_strobe = 1'b0, rd_in_sector = 1'b0;
    logic [7:0] status;
    logic       ready;
    int         n_chk = 0;
    int         n_err = 0;
    logic       finished = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    opstat_gen #(.STATUS_W(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_go      (cmd_go),
        .cmd_is_erase(cmd_is_erase),
        .cmd_data_b7 (cmd_data_b7),
        .op_done     (op_done),
        .over_limit  (over_limit),
        .sus_req     (sus_req),
        .res_req     (res_req),
        .abort_req   (abort_req),
        .win_closed  (win_closed),
        .rd_strobe   (rd_strobe),
        .rd_in_sector(rd_in_sector),
        .status      (status),
        .ready       (ready)
    );

    task automatic check(input logic [23:0] tag, input logic [7:0] exp_s,
                         input logic exp_r);
        n_chk++;
        if (status !== exp_s) begin
            n_err++;
            $display("FAIL %s status got=%h exp=%h", tag, status, exp_s);
        end
        n_chk++;
        if (ready !== exp_r) begin
            n_err++;
            $display("FAIL %s ready got=%b exp=%b", tag, ready, exp_r);
        end
    endtask

    task automatic drive(input logic [10:0] f);
        {cmd_go, cmd_is_erase, cmd_data_b7, op_done, over_limit, sus_req,
         res_req, abort_req, win_closed, rd_strobe, rd_in_sector} = f;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h80, 1'b1);       // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h80, 1'b1);
        for (int i = 0; i < NROWS; i++) begin
            drive(ROWS[i][19:9]);
            @(negedge clk);
            check(TAGS[i], ROWS[i][8:1], ROWS[i][0]);
        end
        drive(11'b0);
        // R1 reset during a busy program returns to idle
        drive(11'b10000000000);
        @(negedge clk);
        check("R9", 8'h80, 1'b0);
        drive(11'b0);
        rst_n = 1'b0;
        #1;
        check("R1", 8'h80, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 cmd_go ignored while busy: second go during erase does not restart
        drive(11'b11000000000);
        @(negedge clk);
        drive(11'b00000000100);
        @(negedge clk);
        drive(11'b10100000000);
        @(negedge clk);
        check("R9", 8'h08, 1'b0);
        drive(11'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule